// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This block takes exception requests from a processor pipeline and turns them into a single redirect. The pipeline raises one request line per exception kind. With each request it supplies a load/store flag, the faulting virtual address, the coprocessor number and the PC of the faulting instruction, plus a flag that says whether that instruction sits in a branch delay slot. In the cycle it accepts a request, the unit picks the highest-priority line and updates its exception registers: the cause code, the coprocessor field, the delay-slot flag, the saved exception PC, the bad-address register and the exception-level bit. In the next cycle it drives the handler address as a redirect with a one-cycle valid strobe.

The handler address depends on three things. The first is the boot-vector bit. The second is the exception level as it stood before entry, which matters for TLB refills. The third is the vectored-interrupt bit, which matters for interrupts. A return-from-exception input clears the exception level and redirects to the saved PC. Software reads and writes the five registers through a small select/write port. An exception request in a cycle takes precedence over a return or a software write in the same cycle.

Top module: `exc_entry_unit`

## Requirements
- R1: When several request lines are high in one cycle, only the lowest-numbered one is taken. The request bit numbers are 0 reset, 1 fetch address error, 2 TLB refill, 3 TLB invalid, 4 TLB modified, 5 coprocessor unusable, 6 reserved instruction, 7 overflow, 8 trap, 9 syscall, 10 breakpoint, 11 data address error and 12 interrupt.
- R2: On entry the 5-bit cause code at cause[6:2] is set as follows: 0xC for overflow, 0xD for trap, 0x9 for breakpoint, 0x8 for syscall, 0x1 for TLB modified, 0xA for reserved instruction and 0x0 for interrupt.
- R3: A fetch address error writes code 0x4. A data address error writes 0x4 for a load and 0x5 for a store. Both copy the faulting address into the bad-address register, and every other kind leaves that register unchanged.
- R4: A TLB refill or TLB invalid exception writes code 0x2 for a load and 0x3 for a store.
- R5: A coprocessor-unusable exception writes code 0xB and places the 2-bit coprocessor number in cause[29:28].
- R6: While status[22] (boot vector) is 1, every non-reset exception is directed to 0xBFC00200.
- R7: While status[22] is 0, the general handler is at the exception base plus 0x180. An interrupt taken while cause[23] is 1 goes to the base plus 0x200.
- R8: A TLB refill taken while status[1] was 0 goes to the base plus 0x000. If status[1] was already 1, it goes to the base plus 0x180.
- R9: A reset request redirects to 0xBFC00000 and leaves the cause, saved PC, bad-address and status registers unchanged.
- R10: If status[1] was 0 on entry, the saved PC takes the faulting PC, or that PC minus 4 when the instruction is in a delay slot, and cause[31] takes the delay-slot flag. If status[1] was already 1, both are left unchanged.
- R11: Every non-reset entry sets status[1]. A return input, with no request in the same cycle, clears status[1] and redirects to the saved PC.
- R12: The redirect valid output is high for exactly the one cycle after a request or return is accepted, and low at all other times.
- R13: Software selects registers with codes 0 status, 1 cause, 2 saved PC, 3 bad address and 4 exception base; any other code reads 0. The writable fields are status bits 22 and 1, cause bit 23, all of the saved PC, and base bits 31:12. The bad-address register is read-only. After reset the registers hold status 0x00400000, base 0x80000000 and 0 everywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 13 | Exception request lines, bit number = priority rank |
| exc_is_store | input | 1 | Faulting access was a store |
| exc_vaddr | input | 32 | Faulting virtual address |
| exc_cop_id | input | 2 | Coprocessor number for coprocessor-unusable |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| eret | input | 1 | Return from exception |
| csr_we | input | 1 | Software register write enable |
| csr_sel | input | 3 | Software register select |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Selected register contents |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Redirect target |

## Verification
The bench sweeps every request kind against both access types, both boot-vector settings, both prior exception levels and both interrupt-vector settings. It then drives every pair of simultaneous requests. A unit that sampled the exception level after setting it would send a first-level TLB refill to the base plus 0x180 instead of the base itself. A unit that overwrote the saved PC on a nested entry would lose the return address. A unit with the priority chain reversed would report the wrong code or the wrong vector. The register checks also catch a reset request that disturbed the cause code, a bad-address register written by non-address faults, and a redirect strobe that stayed high past its single cycle.

// File: rtl/exc_pkg.sv
// Shared types for the exception entry unit.
// Assumes a 32-bit register layout; request bit number equals priority rank.
package exc_pkg;
    localparam int NUM_KINDS = 13;
    localparam int KIND_W    = 4;

    typedef enum logic [KIND_W-1:0] {
        K_RESET        = 4'd0,
        K_ADDR_FETCH   = 4'd1,
        K_TLB_REFILL   = 4'd2,
        K_TLB_INVALID  = 4'd3,
        K_TLB_MOD      = 4'd4,
        K_COP_UNUSABLE = 4'd5,
        K_RESERVED     = 4'd6,
        K_OVERFLOW     = 4'd7,
        K_TRAP         = 4'd8,
        K_SYSCALL      = 4'd9,
        K_BREAK        = 4'd10,
        K_ADDR_DATA    = 4'd11,
        K_INTERRUPT    = 4'd12
    } exc_kind_e;

    localparam logic [2:0] SEL_STATUS = 3'd0;
    localparam logic [2:0] SEL_CAUSE  = 3'd1;
    localparam logic [2:0] SEL_EPC    = 3'd2;
    localparam logic [2:0] SEL_BADV   = 3'd3;
    localparam logic [2:0] SEL_EBASE  = 3'd4;

    localparam int ST_EXL     = 1;
    localparam int ST_BEV     = 22;
    localparam int CA_CODE_LO = 2;
    localparam int CA_CE_LO   = 28;
    localparam int CA_IV      = 23;
    localparam int CA_BD      = 31;

    // Cause code written for a given kind and access direction.
    function automatic logic [4:0] cause_code(exc_kind_e k, logic st);
        case (k)
            K_ADDR_FETCH:                 return 5'h4;
            K_ADDR_DATA:                  return st ? 5'h5 : 5'h4;
            K_TLB_REFILL, K_TLB_INVALID:  return st ? 5'h3 : 5'h2;
            K_TLB_MOD:                    return 5'h1;
            K_COP_UNUSABLE:               return 5'hB;
            K_RESERVED:                   return 5'hA;
            K_OVERFLOW:                   return 5'hC;
            K_TRAP:                       return 5'hD;
            K_SYSCALL:                    return 5'h8;
            K_BREAK:                      return 5'h9;
            default:                      return 5'h0;
        endcase
    endfunction
endpackage

// File: rtl/exc_prio_sel.sv
// Fixed-priority picker: the lowest-numbered active request wins.
// Assumes requests are sampled in the same cycle the pick is used.
module exc_prio_sel #(
    parameter int N  = 13,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] grant;

    // One grant per line, masked by every higher-priority line.
    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    // Encode the winning line number.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;

    p_pick_highest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (grant[idx] && $onehot(grant)));
endmodule

// File: rtl/exc_vec_calc.sv
// Handler address selection from boot bit, prior exception level and
// vectored-interrupt bit. Pure combinational; reset kind handled by caller.
module exc_vec_calc
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  exc_kind_e        kind,
    input  logic             bev,
    input  logic             exl_before,
    input  logic             iv,
    input  logic [XLEN-1:0]  ebase,
    output logic [XLEN-1:0]  handler
);
    localparam logic [XLEN-1:0] BOOT_GEN = XLEN'(32'hBFC0_0200);
    localparam logic [XLEN-1:0] OFS_GEN  = XLEN'(32'h180);
    localparam logic [XLEN-1:0] OFS_INT  = XLEN'(32'h200);

    // Choose the vector for the accepted exception.
    always_comb begin
        if (bev)                                       handler = BOOT_GEN;
        else if (kind == K_TLB_REFILL && !exl_before)  handler = ebase;
        else if (kind == K_INTERRUPT && iv)            handler = ebase + OFS_INT;
        else                                           handler = ebase + OFS_GEN;
    end
endmodule

// File: rtl/exc_csr_file.sv
// Exception registers: status, cause, saved PC, bad address, base.
// Assumes at most one of take / eret / software write acts per cycle,
// with take first and eret second.
module exc_csr_file
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  exc_kind_e        kind,
    input  logic             is_store,
    input  logic [XLEN-1:0]  vaddr,
    input  logic [1:0]       cop_id,
    input  logic [XLEN-1:0]  pc,
    input  logic             in_delay,
    input  logic             eret,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata,
    output logic             bev,
    output logic             exl,
    output logic             iv,
    output logic [XLEN-1:0]  ebase,
    output logic [XLEN-1:0]  epc
);
    localparam logic [XLEN-1:0] ST_WMASK    = XLEN'((1 << ST_BEV) | (1 << ST_EXL));
    localparam logic [XLEN-1:0] CA_WMASK    = XLEN'(1 << CA_IV);
    localparam logic [XLEN-1:0] EBASE_WMASK = ~XLEN'(32'hFFF);
    localparam logic [XLEN-1:0] ST_RESET    = XLEN'(1 << ST_BEV);
    localparam logic [XLEN-1:0] EBASE_RESET = XLEN'(32'h8000_0000);
    localparam logic [XLEN-1:0] PC_STEP     = XLEN'(4);

    logic [XLEN-1:0] status_q, cause_q, epc_q, badv_q, ebase_q;
    logic            entry;

    assign entry = take && (kind != K_RESET);

    // Register updates: exception entry, then return, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_RESET;
            cause_q  <= '0;
            epc_q    <= '0;
            badv_q   <= '0;
            ebase_q  <= EBASE_RESET;
        end else if (entry) begin
            status_q[ST_EXL] <= 1'b1;
            cause_q[CA_CODE_LO +: 5] <= cause_code(kind, is_store);
            if (kind == K_COP_UNUSABLE) cause_q[CA_CE_LO +: 2] <= cop_id;
            if (kind == K_ADDR_FETCH || kind == K_ADDR_DATA) badv_q <= vaddr;
            if (!status_q[ST_EXL]) begin
                epc_q          <= in_delay ? pc - PC_STEP : pc;
                cause_q[CA_BD] <= in_delay;
            end
        end else if (take) begin
            status_q <= status_q;
        end else if (eret) begin
            status_q[ST_EXL] <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_STATUS: status_q <= wdata & ST_WMASK;
                SEL_CAUSE:  cause_q  <= (cause_q & ~CA_WMASK) | (wdata & CA_WMASK);
                SEL_EPC:    epc_q    <= wdata;
                SEL_EBASE:  ebase_q  <= wdata & EBASE_WMASK;
                default:    ;
            endcase
        end
    end

    // Software read mux.
    always_comb begin
        case (sel)
            SEL_STATUS: rdata = status_q;
            SEL_CAUSE:  rdata = cause_q;
            SEL_EPC:    rdata = epc_q;
            SEL_BADV:   rdata = badv_q;
            SEL_EBASE:  rdata = ebase_q;
            default:    rdata = '0;
        endcase
    end

    assign bev   = status_q[ST_BEV];
    assign exl   = status_q[ST_EXL];
    assign iv    = cause_q[CA_IV];
    assign ebase = ebase_q;
    assign epc   = epc_q;

    p_exl_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> exl);
    p_eret_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !take) |=> !exl);
    p_epc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && exl) |=> $stable(epc_q));
    p_reset_keeps_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == K_RESET) |=> ($stable(cause_q) && $stable(status_q)));
endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry and vectoring unit: picks one request, updates the
// exception registers and issues a registered one-cycle redirect.
// Assumes the pipeline holds a request for exactly the cycle it is raised.
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] exc_req,
    input  logic                 exc_is_store,
    input  logic [XLEN-1:0]      exc_vaddr,
    input  logic [1:0]           exc_cop_id,
    input  logic [XLEN-1:0]      exc_pc,
    input  logic                 exc_in_delay,
    input  logic                 eret,
    input  logic                 csr_we,
    input  logic [2:0]           csr_sel,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    output logic                 redir_valid,
    output logic [XLEN-1:0]      redir_pc
);
    localparam logic [XLEN-1:0] BOOT_VEC = XLEN'(32'hBFC0_0000);

    logic              take;
    logic [KIND_W-1:0] kind_idx;
    exc_kind_e         kind;
    logic              bev, exl, iv;
    logic [XLEN-1:0]   ebase, epc, handler;

    exc_prio_sel #(.N(NUM_KINDS)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (exc_req),
        .any   (take),
        .idx   (kind_idx)
    );

    assign kind = exc_kind_e'(kind_idx);

    exc_vec_calc #(.XLEN(XLEN)) u_vec (
        .kind       (kind),
        .bev        (bev),
        .exl_before (exl),
        .iv         (iv),
        .ebase      (ebase),
        .handler    (handler)
    );

    exc_csr_file #(.XLEN(XLEN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .kind     (kind),
        .is_store (exc_is_store),
        .vaddr    (exc_vaddr),
        .cop_id   (exc_cop_id),
        .pc       (exc_pc),
        .in_delay (exc_in_delay),
        .eret     (eret),
        .we       (csr_we),
        .sel      (csr_sel),
        .wdata    (csr_wdata),
        .rdata    (csr_rdata),
        .bev      (bev),
        .exl      (exl),
        .iv       (iv),
        .ebase    (ebase),
        .epc      (epc)
    );

    // Registered redirect: strobe and target one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
        end else begin
            redir_valid <= take | eret;
            if (take)      redir_pc <= (kind == K_RESET) ? BOOT_VEC : handler;
            else if (eret) redir_pc <= epc;
        end
    end

    p_pulse_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take || eret) |=> redir_valid);
    p_quiet_otherwise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(take || eret) |=> !redir_valid);
    p_boot_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req[0] |=> (redir_pc == BOOT_VEC));
endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] exc_req = '0;
    logic        exc_is_store = 1'b0;
    logic [31:0] exc_vaddr = '0;
    logic [1:0]  exc_cop_id = '0;
    logic [31:0] exc_pc = '0;
    logic        exc_in_delay = 1'b0;
    logic        eret = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        redir_valid;
    logic [31:0] redir_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_is_store(exc_is_store),
        .exc_vaddr(exc_vaddr), .exc_cop_id(exc_cop_id), .exc_pc(exc_pc),
        .exc_in_delay(exc_in_delay), .eret(eret), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redir_valid(redir_valid),
        .redir_pc(redir_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        csr_sel = sel;
        #1 d = csr_rdata;
    endtask

    function automatic logic [4:0] exp_code(input int k, input logic st);
        case (k)
            1: return 5'h4;
            11: return st ? 5'h5 : 5'h4;
            2, 3: return st ? 5'h3 : 5'h2;
            4: return 5'h1;
            5: return 5'hB;
            6: return 5'hA;
            7: return 5'hC;
            8: return 5'hD;
            9: return 5'h8;
            10: return 5'h9;
            default: return 5'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_vec(input int k, input logic bev, input logic exl,
                                            input logic iv, input logic [31:0] eb);
        if (k == 0) return 32'hBFC0_0000;
        if (bev) return 32'hBFC0_0200;
        if (k == 2 && !exl) return eb;
        if (k == 12 && iv) return eb + 32'h200;
        return eb + 32'h180;
    endfunction

    function automatic string code_tag(input int k);
        if (k == 1 || k == 11) return "R3";
        if (k == 2 || k == 3) return "R4";
        if (k == 5) return "R5";
        return "R2";
    endfunction

    function automatic string vec_tag(input int k, input logic bev);
        if (k == 0) return "R9";
        if (bev) return "R6";
        if (k == 2) return "R8";
        return "R7";
    endfunction

    task automatic fire(input logic [12:0] req, input logic st, input logic [31:0] va,
                        input logic [1:0] cop, input logic [31:0] pc, input logic bd,
                        input logic [31:0] exp_pc, input string tag);
        @(negedge clk);
        exc_req = req; exc_is_store = st; exc_vaddr = va;
        exc_cop_id = cop; exc_pc = pc; exc_in_delay = bd;
        @(negedge clk);
        exc_req = '0;
        check("R12", {31'd0, redir_valid}, 32'd1);
        check(tag, redir_pc, exp_pc);
        @(negedge clk);
        check("R12", {31'd0, redir_valid}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, pre_cause, pre_badv, cause, status, epc, badv, eb, pc, va;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset values and write masks
        check("R12", {31'd0, redir_valid}, 32'd0);
        rd(3'd0, v); check("R13", v, 32'h0040_0000);
        rd(3'd1, v); check("R13", v, 32'h0);
        rd(3'd2, v); check("R13", v, 32'h0);
        rd(3'd3, v); check("R13", v, 32'h0);
        rd(3'd4, v); check("R13", v, 32'h8000_0000);
        rd(3'd6, v); check("R13", v, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R13", v, 32'h0040_0002);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); check("R13", v, 32'h0080_0000);
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R13", v, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check("R13", v, 32'hFFFF_F000);
        wr(3'd2, 32'h1234_5678); rd(3'd2, v); check("R13", v, 32'h1234_5678);
        wr(3'd1, 32'h0);

        // R11: return clears the level and redirects to the saved PC
        wr(3'd0, 32'h2); wr(3'd2, 32'h00AB_CD00);
        @(negedge clk); eret = 1'b1;
        @(negedge clk); eret = 1'b0;
        check("R12", {31'd0, redir_valid}, 32'd1);
        check("R11", redir_pc, 32'h00AB_CD00);
        @(negedge clk);
        check("R12", {31'd0, redir_valid}, 32'd0);
        rd(3'd0, v); check("R11", v & 32'h2, 32'h0);

        // Sweep every kind over store, boot bit, prior level and vectored bit
        for (int k = 0; k < 13; k++) begin
            for (int m = 0; m < 16; m++) begin
                logic st, bev, exl, iv, bd;
                st = m[0]; bev = m[1]; exl = m[2]; iv = m[3];
                bd = k[0] ^ st;
                eb = 32'h8000_0000 + (32'(k) << 12);
                pc = 32'h0040_1000 + 32'(k) * 16;
                va = 32'h1234_0000 ^ (32'(k) << 4) ^ 32'(st);
                wr(3'd0, ({31'd0, bev} << 22) | ({31'd0, exl} << 1));
                wr(3'd1, {31'd0, iv} << 23);
                wr(3'd2, 32'h0000_5550 + 32'(k));
                wr(3'd4, eb);
                rd(3'd1, pre_cause);
                rd(3'd3, pre_badv);
                fire(13'(1) << k, st, va, 2'(k + m), pc, bd,
                     exp_vec(k, bev, exl, iv, eb), vec_tag(k, bev));
                rd(3'd1, cause); rd(3'd0, status); rd(3'd2, epc); rd(3'd3, badv);
                if (k == 0) begin
                    check("R9", cause, pre_cause);
                    check("R9", status, ({31'd0, bev} << 22) | ({31'd0, exl} << 1));
                    check("R9", epc, 32'h0000_5550);
                end else begin
                    check(code_tag(k), {27'd0, cause[6:2]}, {27'd0, exp_code(k, st)});
                    check("R11", {31'd0, status[1]}, 32'd1);
                    check("R13", {31'd0, cause[23]}, {31'd0, iv});
                    if (!exl) begin
                        check("R10", epc, bd ? pc - 32'd4 : pc);
                        check("R10", {31'd0, cause[31]}, {31'd0, bd});
                    end else begin
                        check("R10", epc, 32'h0000_5550 + 32'(k));
                        check("R10", {31'd0, cause[31]}, {31'd0, pre_cause[31]});
                    end
                    if (k == 5) check("R5", {30'd0, cause[29:28]}, {30'd0, 2'(k + m)});
                end
                if (k == 1 || k == 11) check("R3", badv, va);
                else check("R3", badv, pre_badv);
            end
        end

        // R1: every pair of simultaneous requests, lower number wins
        eb = 32'h9000_0000;
        wr(3'd4, eb); wr(3'd1, 32'h0);
        for (int i = 0; i < 13; i++) begin
            for (int j = i + 1; j < 13; j++) begin
                wr(3'd0, 32'h0);
                rd(3'd1, pre_cause);
                fire((13'(1) << i) | (13'(1) << j), 1'b1, 32'h0000_0F00, 2'd1,
                     32'h0040_2000, 1'b0, exp_vec(i, 1'b0, 1'b0, 1'b0, eb), "R1");
                rd(3'd1, cause);
                if (i == 0) check("R1", cause, pre_cause);
                else check("R1", {27'd0, cause[6:2]}, {27'd0, exp_code(i, 1'b1)});
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule